// File: doc/BRIEF.md
# Masked Pattern and Change Detector

This block watches an 8-bit digital port whose bits can each be set as an input or an output. Once a port bit is past a two-flop synchroniser, a divided sampling tick samples it. That tick filters out short glitches. The block then checks the input bits that are not masked in one of two ways. In change mode, any difference between two consecutive samples counts as a detection. In match mode, a detection occurs when the sampled bits become equal to a programmed compare value. A detection sets a sticky status bit that software clears by writing 1 to it. That status bit can drive the interrupt line and a wake request.

A second, narrower port has its own strobe pin. A rising edge on the strobe captures that port's value and sets a second sticky status bit, which also feeds the interrupt. The host reaches every setting through a small register interface: a write strobe, an address and 8-bit write data, with read data decoded combinationally from the address.

Top module: `pattern_watch`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq`, `wake_req`, `pa_oe` and `pa_out` are all 0.
- R2: `pa_oe` equals the direction register at address 2, where 1 means output. `pa_out` equals the last value written to address 0.
- R3: Reading address 0 returns the written value on output bits. On input bits it returns the pin value held at the most recent sampling tick.
- R4: Pins pass through two flops and are sampled once every `SAMPLE_DIV` clocks. A level that is not present at a sampling tick is never seen.
- R5: Bits set in the mask register (address 3) never take part in detection. Bits configured as outputs never take part either.
- R6: When control bits [4:3] = 2'b10, any difference between two consecutive samples on a considered bit sets control bit 6 at that tick. When bits [4:3] are 2'b00 or 2'b01, nothing sets it.
- R7: When control bits [4:3] = 2'b11, control bit 6 is set at a tick where the considered bits equal the compare register (address 4) and did not equal it at the previous tick. A condition that stays true sets it only once.
- R8: Control bit 6 stays set until a write to address 5 with data bit 6 = 1. Writing 0 there leaves it unchanged, and a new detection in the same cycle wins over the clear.
- R9: `irq` is high while control bit 0 (interrupt enable) is 1 and control bit 6 or bit 7 is set.
- R10: A rising edge on `pb_stb` captures `pb_in`, readable at address 1 zero-extended, and sets control bit 7, which is cleared by writing 1 to it. `pb_in` changes without a strobe leave address 1 unchanged.
- R11: `wake_req` is high while bit 0 of the wake register (address 6) is 1 and control bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | PB_W | Port B pin values |
| pb_stb | input | 1 | Port B capture strobe |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake request |

## Verification
A pin change reaches the synchronised value two clocks later. Detection uses that value only at the next sampling tick, and the status bit, `irq` and `wake_req` change at that same tick edge. A strobe edge sets its status bit and captures port B three clock edges after the pin rises. The bench reference model delays the pins and the strobe through queues of the same depth and counts ticks from the release of reset. It updates at each rising edge and compares every output half a period later. Directed checks wait several sampling periods after each stimulus so they read settled values. The glitch test places its one-clock pulse right after a tick, so the pulse falls between two ticks.

// File: rtl/pw_pkg.sv
// Package: shared widths, register addresses and the detection mode type.
package pw_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] RA_PORTA = 3'd0;
    localparam logic [AW-1:0] RA_PORTB = 3'd1;
    localparam logic [AW-1:0] RA_DIR   = 3'd2;
    localparam logic [AW-1:0] RA_MASK  = 3'd3;
    localparam logic [AW-1:0] RA_CMP   = 3'd4;
    localparam logic [AW-1:0] RA_CTRL  = 3'd5;
    localparam logic [AW-1:0] RA_WAKE  = 3'd6;

    localparam int CTL_IE    = 0;
    localparam int CTL_MODE  = 3;
    localparam int CTL_DET   = 6;
    localparam int CTL_STB   = 7;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_RSVD  = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_MATCH = 2'b11
    } det_mode_e;
endpackage

// File: rtl/pw_sync.sv
// Module: pw_sync
// Two-flop synchroniser for a bus of asynchronous pins.
// Assumes each bit is treated independently, so bus skew is acceptable.
module pw_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Move the pins through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pw_tick.sv
// Module: pw_tick
// Makes a one-clock sampling pulse once every DIV clocks.
// Assumes DIV >= 2. The first pulse comes DIV clocks after reset is released.
module pw_tick #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count clocks and wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pw_detect.sv
// Module: pw_detect
// Samples the synchronised port at each tick and runs the change or match
// detection on the considered bits. It keeps the sticky detection flag.
// Assumes care/cmp/mode are register outputs that are stable around the tick.
module pw_detect
    import pw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] sync_val,
    input  logic [W-1:0] care,
    input  logic [W-1:0] cmp,
    input  det_mode_e    mode,
    input  logic         clr,
    output logic [W-1:0] samp,
    output logic         flag
);
    logic cond_now;
    logic cond_prev;
    logic changed;
    logic hit;

    assign cond_now = (((sync_val ^ cmp) & care) == '0);
    assign changed  = (((sync_val ^ samp) & care) != '0);

    // Decide whether this tick produces a detection in the current mode.
    always_comb begin
        hit = 1'b0;
        if (tick) begin
            case (mode)
                MODE_EVENT: hit = changed;
                MODE_MATCH: hit = cond_now && !cond_prev;
                default:    hit = 1'b0;
            endcase
        end
    end

    // Hold the sample, the previous match state and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp      <= '0;
            cond_prev <= 1'b0;
            flag      <= 1'b0;
        end else begin
            if (tick) begin
                samp      <= sync_val;
                cond_prev <= cond_now;
            end
            if (hit)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pw_strobe.sv
// Module: pw_strobe
// Captures the synchronised port B value on a rising strobe edge and
// keeps a sticky strobe flag.
// Assumes the strobe and data come through synchronisers of equal depth.
module pw_strobe #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_s,
    input  logic [W-1:0] data_s,
    input  logic         clr,
    output logic [W-1:0] latch,
    output logic         flag
);
    logic stb_d;
    logic rise;

    assign rise = stb_s && !stb_d;

    // Find the strobe edge, capture the data and set the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_d <= 1'b0;
            latch <= '0;
            flag  <= 1'b0;
        end else begin
            stb_d <= stb_s;
            if (rise) latch <= data_s;
            if (rise)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pattern_watch.sv
// Module: pattern_watch (top)
// Register file, port A direction and output latch, read mux, and the
// interrupt and wake gating around the sampler, detector and strobe blocks.
// Assumes a single-cycle write strobe and a combinational read.
module pattern_watch
    import pw_pkg::*;
#(
    parameter int SAMPLE_DIV = 6,
    parameter int PB_W       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic [7:0]      pa_in,
    output logic [7:0]      pa_out,
    output logic [7:0]      pa_oe,
    input  logic [PB_W-1:0] pb_in,
    input  logic            pb_stb,
    output logic            irq,
    output logic            wake_req
);
    logic [DW-1:0]   dir_q, out_q, mask_q, cmp_q;
    logic            ie_q, wake_en_q;
    det_mode_e       mode_q;
    logic [DW-1:0]   pa_s, samp;
    logic [PB_W-1:0] pb_s, pb_latch;
    logic            stb_s, tick, det_flag, stb_flag;
    logic            ctrl_wr, det_clr, stb_clr;
    logic [DW-1:0]   care, porta_rd, ctrl_rd;

    assign ctrl_wr = wr_en && (addr == RA_CTRL);
    assign det_clr = ctrl_wr && wdata[CTL_DET];
    assign stb_clr = ctrl_wr && wdata[CTL_STB];
    assign care    = ~mask_q & ~dir_q;

    pw_sync #(.W(DW))   u_sync_a (.clk(clk), .rst_n(rst_n), .d(pa_in),  .q(pa_s));
    pw_sync #(.W(PB_W)) u_sync_b (.clk(clk), .rst_n(rst_n), .d(pb_in),  .q(pb_s));
    pw_sync #(.W(1))    u_sync_s (.clk(clk), .rst_n(rst_n), .d(pb_stb), .q(stb_s));

    pw_tick #(.DIV(SAMPLE_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    pw_detect #(.W(DW)) u_det (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sync_val(pa_s), .care(care),
        .cmp(cmp_q), .mode(mode_q), .clr(det_clr), .samp(samp), .flag(det_flag)
    );

    pw_strobe #(.W(PB_W)) u_stb (
        .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .data_s(pb_s),
        .clr(stb_clr), .latch(pb_latch), .flag(stb_flag)
    );

    // Host writes into the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            out_q     <= '0;
            mask_q    <= '0;
            cmp_q     <= '0;
            ie_q      <= 1'b0;
            mode_q    <= MODE_OFF;
            wake_en_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                RA_PORTA: out_q  <= wdata;
                RA_DIR:   dir_q  <= wdata;
                RA_MASK:  mask_q <= wdata;
                RA_CMP:   cmp_q  <= wdata;
                RA_CTRL: begin
                    ie_q   <= wdata[CTL_IE];
                    mode_q <= det_mode_e'(wdata[CTL_MODE+1:CTL_MODE]);
                end
                RA_WAKE:  wake_en_q <= wdata[0];
                default: ;
            endcase
        end
    end

    assign porta_rd = (dir_q & out_q) | (~dir_q & samp);

    // Put together the control and status byte.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTL_IE] = ie_q;
        ctrl_rd[CTL_MODE+1:CTL_MODE] = mode_q;
        ctrl_rd[CTL_DET] = det_flag;
        ctrl_rd[CTL_STB] = stb_flag;
    end

    // Read mux by address.
    always_comb begin
        case (addr)
            RA_PORTA: rdata = porta_rd;
            RA_PORTB: rdata = DW'(pb_latch);
            RA_DIR:   rdata = dir_q;
            RA_MASK:  rdata = mask_q;
            RA_CMP:   rdata = cmp_q;
            RA_CTRL:  rdata = ctrl_rd;
            RA_WAKE:  rdata = {7'd0, wake_en_q};
            default:  rdata = '0;
        endcase
    end

    assign pa_out   = out_q;
    assign pa_oe    = dir_q;
    assign irq      = ie_q && (det_flag || stb_flag);
    assign wake_req = wake_en_q && det_flag;
endmodule

// File: rtl/pw_checker.sv
// Module: pw_checker
// Temporal checks on pattern_watch, attached with bind below.
module pw_checker
    import pw_pkg::*;
#(
    parameter int PB_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      addr,
    input logic [7:0]      wdata,
    input logic [7:0]      pa_oe,
    input logic            irq,
    input logic            wake_req,
    input logic            tick,
    input logic            det_flag,
    input logic            stb_flag,
    input logic [PB_W-1:0] pb_latch
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !wake_req && pa_oe == '0)); // R1
    AST_OE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pa_oe) |-> $past(wr_en && addr == RA_DIR)); // R2
    AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_flag) |-> $past(tick)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_flag) |-> $past(wr_en && addr == RA_CTRL && wdata[CTL_DET])); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (det_flag || stb_flag)); // R9
    AST_LATCH_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pb_latch) |-> stb_flag); // R10
    AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> det_flag); // R11
endmodule

bind pattern_watch pw_checker #(.PB_W(PB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pa_oe(pa_oe), .irq(irq), .wake_req(wake_req), .tick(tick),
    .det_flag(det_flag), .stb_flag(stb_flag), .pb_latch(pb_latch)
);

// File: tb/sim_pattern_watch.sv
module sim_pattern_watch;
    localparam int DIV  = 6;
    localparam int PB_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic [7:0]      pa_in = '0;
    logic [7:0]      pa_out, pa_oe;
    logic [PB_W-1:0] pb_in = '0;
    logic            pb_stb = 1'b0;
    logic            irq, wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pattern_watch #(.SAMPLE_DIV(DIV), .PB_W(PB_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_stb(pb_stb), .irq(irq), .wake_req(wake_req)
    );

    always #10 clk = ~clk;

    // Reference model state
    logic [7:0] m_dir, m_out, m_mask, m_cmp, m_samp;
    logic [1:0] m_mode;
    logic       m_ie, m_wk, m_flag, m_sflag, m_prev, m_lasttick;
    logic [PB_W-1:0] m_bl;
    logic [7:0] pa_q[$];
    logic       st_q[$];
    logic [PB_W-1:0] pb_q[$];
    logic       st_old;
    int         cyc;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return (m_dir & m_out) | (~m_dir & m_samp);
            3'd1: return 8'(m_bl);
            3'd2: return m_dir;
            3'd3: return m_mask;
            3'd4: return m_cmp;
            3'd5: return {m_sflag, m_flag, 1'b0, m_mode, 2'b00, m_ie};
            3'd6: return {7'd0, m_wk};
            default: return 8'd0;
        endcase
    endfunction

    // Behavioural reference, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_mask = 0; m_cmp = 0; m_samp = 0; m_mode = 0;
            m_ie = 0; m_wk = 0; m_flag = 0; m_sflag = 0; m_prev = 0; m_bl = 0;
            m_lasttick = 0; st_old = 0; cyc = 0;
            pa_q = '{8'd0, 8'd0}; st_q = '{1'b0, 1'b0}; pb_q = '{'0, '0};
        end else begin
            logic [7:0] seen, care;
            logic tk, cond, hit, rise, st_seen;
            seen = pa_q[0]; st_seen = st_q[0];
            tk = ((cyc % DIV) == DIV - 1);
            cyc++;
            care = ~m_mask & ~m_dir;
            hit = 0;
            if (tk) begin
                cond = (((seen ^ m_cmp) & care) == 0);
                if (m_mode == 2'b10 && (((seen ^ m_samp) & care) != 0)) hit = 1;
                if (m_mode == 2'b11 && cond && !m_prev) hit = 1;
                m_prev = cond;
                m_samp = seen;
            end
            m_lasttick = tk;
            rise = st_seen && !st_old;
            st_old = st_seen;
            if (rise) m_bl = pb_q[0];
            if (hit) m_flag = 1;
            else if (wr_en && addr == 3'd5 && wdata[6]) m_flag = 0;
            if (rise) m_sflag = 1;
            else if (wr_en && addr == 3'd5 && wdata[7]) m_sflag = 0;
            if (wr_en) begin
                case (addr)
                    3'd0: m_out = wdata;
                    3'd2: m_dir = wdata;
                    3'd3: m_mask = wdata;
                    3'd4: m_cmp = wdata;
                    3'd5: begin m_ie = wdata[0]; m_mode = wdata[4:3]; end
                    3'd6: m_wk = wdata[0];
                    default: ;
                endcase
            end
            void'(pa_q.pop_front()); pa_q.push_back(pa_in);
            void'(st_q.pop_front()); st_q.push_back(pb_stb);
            void'(pb_q.pop_front()); pb_q.push_back(pb_in);
        end
    end

    // Compare every output to the model half a period after each edge.
    always begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            chk("R2 pa_out", pa_out, m_out);
            chk("R2 pa_oe", pa_oe, m_dir);
            chk("R3 rdata", rdata, m_read(addr));
            chk("R9 irq", irq, m_ie & (m_flag | m_sflag));
            chk("R11 wake_req", wake_req, m_wk & m_flag);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic settle();
        repeat (3 * DIV) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a;
        @(posedge clk); #5;
        chk(tag, rdata, exp);
    endtask

    task automatic sig(input logic act, input logic exp, input string tag);
        @(posedge clk); #5;
        chk(tag, act, exp);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog (all) actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R1 reset register");
        sig(irq, 1'b0, "R1 irq");
        sig(wake_req, 1'b0, "R1 wake_req");
        // R2 / R3: direction, output latch, read mix
        pa_in = 8'h3C;
        wr(3'd2, 8'hF0);
        wr(3'd0, 8'hA5);
        settle();
        chk("R2 pa_oe", pa_oe, 8'hF0);
        chk("R2 pa_out", pa_out, 8'hA5);
        rd(3'd0, 8'hAC, "R3 port A read");
        // Change mode, interrupt enabled, mask bits 1:0
        wr(3'd3, 8'h03);
        wr(3'd5, 8'h11);
        settle();
        rd(3'd5, 8'h11, "R6 idle event mode");
        // R5: masked bit and output bit changes are ignored
        pa_in = 8'h3D; settle();
        rd(3'd5, 8'h11, "R5 masked bit");
        pa_in = 8'hBD; settle();
        rd(3'd5, 8'h11, "R5 output bit");
        sig(irq, 1'b0, "R5 irq quiet");
        // R4: one-clock glitch placed between two ticks
        @(negedge clk);
        while (!m_lasttick) @(negedge clk);
        pa_in = 8'hB9;
        @(negedge clk); pa_in = 8'hBD;
        settle();
        rd(3'd5, 8'h11, "R4 glitch filtered");
        // R6 / R9: real change on an unmasked input bit
        pa_in = 8'hB9; settle();
        rd(3'd5, 8'h51, "R6 event detected");
        sig(irq, 1'b1, "R9 irq on detect");
        sig(wake_req, 1'b0, "R11 wake disabled");
        wr(3'd6, 8'h01);
        sig(wake_req, 1'b1, "R11 wake enabled");
        // R8: write-one-to-clear
        wr(3'd5, 8'h11); settle();
        rd(3'd5, 8'h51, "R8 write zero keeps flag");
        wr(3'd5, 8'h51); settle();
        rd(3'd5, 8'h11, "R8 write one clears");
        sig(irq, 1'b0, "R9 irq after clear");
        sig(wake_req, 1'b0, "R11 wake after clear");
        // R7: match mode, edge qualified
        wr(3'd5, 8'h19); settle();
        rd(3'd5, 8'h19, "R7 no match yet");
        wr(3'd4, 8'h08); settle();
        rd(3'd5, 8'h59, "R7 match detected");
        wr(3'd5, 8'h59); settle(); settle();
        rd(3'd5, 8'h19, "R7 steady match no retrigger");
        pa_in = 8'hB5; settle();
        rd(3'd5, 8'h19, "R7 mismatch");
        pa_in = 8'hB9; settle();
        rd(3'd5, 8'h59, "R7 match again");
        // R6: disabled mode ignores changes
        wr(3'd5, 8'h41);
        pa_in = 8'hB5; settle();
        rd(3'd5, 8'h01, "R6 mode off");
        sig(irq, 1'b0, "R9 irq mode off");
        // R10: strobe capture
        pb_in = 4'h9;
        @(negedge clk); pb_stb = 1;
        repeat (2) @(negedge clk); pb_stb = 0;
        settle();
        rd(3'd1, 8'h09, "R10 strobe capture");
        rd(3'd5, 8'h81, "R10 strobe flag");
        sig(irq, 1'b1, "R9 irq on strobe");
        pb_in = 4'h6; settle();
        rd(3'd1, 8'h09, "R10 no capture without strobe");
        wr(3'd5, 8'h81); settle();
        rd(3'd5, 8'h01, "R10 strobe flag cleared");
        settle();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule